// File: doc/BRIEF.md
# Main Control Decoder with Jump-and-Link

This block is the main control unit of a 32-bit single-cycle processor. It looks only at the 6-bit major opcode of the fetched instruction. From it, the block produces every control strobe that steers the datapath: the register-file destination select, the second ALU operand select, the write-back data select, the register and memory enables, the branch and jump flags, and the 2-bit operation class sent to the ALU function decoder.

The decoder is purely combinational, so the strobes settle in the same cycle as the opcode. It handles register-register arithmetic, word load, word store, branch-on-equal, unconditional jump, and jump-and-link. To support the link operation, the destination select and the write-back select are each two bits wide. This lets a call instruction write the return address (PC+4) into register 31 without any extra datapath control line.

Internally, one stage classifies the opcode into a one-hot instruction class. A second stage maps that class onto a packed strobe bundle. A thin top then spreads the bundle onto the ports.

Top module: `mainCtrlDecoder`

## Requirements
- R1: Opcode 000000 (register format) gives regDst=01 (rd), aluSrc=0, memToReg=00 (ALU result), regWrite=1, memRead=0, memWrite=0, branch=0, aluOp=10, jump=0.
- R2: Opcode 100011 (load word) gives regDst=00 (rt), aluSrc=1, memToReg=01 (memory data), regWrite=1, memRead=1, memWrite=0, branch=0, aluOp=00, jump=0.
- R3: Opcode 101011 (store word) gives aluSrc=1, memWrite=1, regWrite=0, memRead=0, branch=0, aluOp=00, jump=0. Its unused selects regDst and memToReg are driven to 00.
- R4: Opcode 000100 (branch-on-equal) gives branch=1, aluOp=01, aluSrc=0, regWrite=0, memRead=0, memWrite=0, jump=0, regDst=00, memToReg=00.
- R5: Opcode 000010 (jump) gives jump=1 with every other output 0 (including aluOp=00).
- R6: Opcode 000011 (jump-and-link) gives regDst=10 (register 31), memToReg=10 (PC+4), regWrite=1, jump=1, aluSrc=0, memRead=0, memWrite=0, branch=0, aluOp=00.
- R7: Any other opcode drives every output to 0, so the instruction changes no register, memory location or program flow.
- R8: The outputs depend only on the present opcode, and follow a change of it without any clock edge.
- R9: memRead and memWrite are never both 1, and regWrite and memWrite are never both 1.
- R10: regDst selects register 31 (10) exactly when memToReg selects PC+4 (10).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 6 | Major opcode field of the current instruction |
| regDst | output | 2 | Write-register select: 00 rt, 01 rd, 10 register 31 |
| aluSrc | output | 1 | Second ALU operand: 0 register, 1 immediate |
| memToReg | output | 2 | Write-back select: 00 ALU, 01 memory, 10 PC+4 |
| regWrite | output | 1 | Register file write enable |
| memRead | output | 1 | Data memory read enable |
| memWrite | output | 1 | Data memory write enable |
| branch | output | 1 | Conditional branch flag |
| aluOp | output | 2 | Operation class for the ALU function decoder |
| jump | output | 1 | Unconditional jump flag |

## Verification
A wrong class decode shows up at the ports in the same evaluation as the opcode change. It appears either as a whole control vector belonging to another instruction, or as a stray enable on an opcode that should do nothing. For this reason, every one of the 64 opcodes is compared against its expected vector. A mis-set field inside a single class, such as a link write-back pointing at the ALU result, is caught by the directed check for that instruction and by the pairing rule between the two select fields.

// File: rtl/mainCtrlPkg.sv
package mainCtrlPkg;

  localparam int OP_W    = 6;
  localparam int SEL_W   = 2;
  localparam int ALUOP_W = 2;

  localparam int CLS_RTYPE = 0;
  localparam int CLS_LOAD  = 1;
  localparam int CLS_STORE = 2;
  localparam int CLS_BEQ   = 3;
  localparam int CLS_JUMP  = 4;
  localparam int CLS_LINK  = 5;
  localparam int NUM_CLS   = 6;

  typedef enum logic [SEL_W-1:0] {
    DST_RT = 2'b00,
    DST_RD = 2'b01,
    DST_RA = 2'b10
  } regDstSel_e;

  typedef enum logic [SEL_W-1:0] {
    WB_ALU  = 2'b00,
    WB_MEM  = 2'b01,
    WB_LINK = 2'b10
  } wbSel_e;

  typedef enum logic [ALUOP_W-1:0] {
    ALU_ADD   = 2'b00,
    ALU_SUB   = 2'b01,
    ALU_FUNCT = 2'b10
  } aluOpSel_e;

  typedef struct packed {
    regDstSel_e regDst;
    logic       aluSrc;
    wbSel_e     memToReg;
    logic       regWrite;
    logic       memRead;
    logic       memWrite;
    logic       branch;
    aluOpSel_e  aluOp;
    logic       jump;
  } ctrlStrobes_t;

  function automatic logic [OP_W-1:0] clsOpcode(input int idx);
    case (idx)
      CLS_RTYPE: clsOpcode = 6'b000000;
      CLS_LOAD:  clsOpcode = 6'b100011;
      CLS_STORE: clsOpcode = 6'b101011;
      CLS_BEQ:   clsOpcode = 6'b000100;
      CLS_JUMP:  clsOpcode = 6'b000010;
      default:   clsOpcode = 6'b000011;
    endcase
  endfunction

endpackage

// File: rtl/opClassifier.sv
module opClassifier
  import mainCtrlPkg::*;
(
  input  logic [OP_W-1:0]    opcode,
  output logic [NUM_CLS-1:0] clsHit
);

  for (genvar g = 0; g < NUM_CLS; g++) begin : gMatch
    assign clsHit[g] = (opcode == clsOpcode(g));
  end

  always_comb begin
    // R7
    one_class_chk: assert ($onehot0(clsHit))
      else $error("opcode matched several classes");
  end

endmodule

// File: rtl/ctrlVectorGen.sv
module ctrlVectorGen
  import mainCtrlPkg::*;
(
  input  logic [NUM_CLS-1:0] clsHit,
  output ctrlStrobes_t       strobes
);

  always_comb begin
    strobes = '0;
    if (clsHit[CLS_RTYPE]) begin
      strobes.regDst   = DST_RD;
      strobes.regWrite = 1'b1;
      strobes.aluOp    = ALU_FUNCT;
    end else if (clsHit[CLS_LOAD]) begin
      strobes.aluSrc   = 1'b1;
      strobes.memToReg = WB_MEM;
      strobes.regWrite = 1'b1;
      strobes.memRead  = 1'b1;
    end else if (clsHit[CLS_STORE]) begin
      strobes.aluSrc   = 1'b1;
      strobes.memWrite = 1'b1;
    end else if (clsHit[CLS_BEQ]) begin
      strobes.branch   = 1'b1;
      strobes.aluOp    = ALU_SUB;
    end else if (clsHit[CLS_JUMP]) begin
      strobes.jump     = 1'b1;
    end else if (clsHit[CLS_LINK]) begin
      strobes.regDst   = DST_RA;
      strobes.memToReg = WB_LINK;
      strobes.regWrite = 1'b1;
      strobes.jump     = 1'b1;
    end
  end

  always_comb begin
    // R6
    link_path_chk: assert (!clsHit[CLS_LINK] ||
        (strobes.regDst == DST_RA && strobes.memToReg == WB_LINK && strobes.jump && strobes.regWrite))
      else $error("link strobes wrong");
    // R7
    unknown_quiet_chk: assert (clsHit != '0 ||
        !(strobes.regWrite || strobes.memWrite || strobes.memRead || strobes.branch || strobes.jump))
      else $error("unknown opcode produced an effect");
    // R9
    mem_excl_chk: assert (!(strobes.memRead && strobes.memWrite) && !(strobes.regWrite && strobes.memWrite))
      else $error("conflicting enables");
    // R10
    link_pair_chk: assert ((strobes.regDst == DST_RA) == (strobes.memToReg == WB_LINK))
      else $error("link selects not paired");
    // R4
    branch_cmp_chk: assert (!strobes.branch || (strobes.aluOp == ALU_SUB && !strobes.regWrite))
      else $error("branch without compare");
  end

endmodule

// File: rtl/mainCtrlDecoder.sv
module mainCtrlDecoder
  import mainCtrlPkg::*;
(
  input  logic [OP_W-1:0]    opcode,
  output logic [SEL_W-1:0]   regDst,
  output logic               aluSrc,
  output logic [SEL_W-1:0]   memToReg,
  output logic               regWrite,
  output logic               memRead,
  output logic               memWrite,
  output logic               branch,
  output logic [ALUOP_W-1:0] aluOp,
  output logic               jump
);

  logic [NUM_CLS-1:0] clsHit;
  ctrlStrobes_t       strobes;

  opClassifier uClass (
    .opcode (opcode),
    .clsHit (clsHit)
  );

  ctrlVectorGen uGen (
    .clsHit  (clsHit),
    .strobes (strobes)
  );

  assign regDst   = strobes.regDst;
  assign aluSrc   = strobes.aluSrc;
  assign memToReg = strobes.memToReg;
  assign regWrite = strobes.regWrite;
  assign memRead  = strobes.memRead;
  assign memWrite = strobes.memWrite;
  assign branch   = strobes.branch;
  assign aluOp    = strobes.aluOp;
  assign jump     = strobes.jump;

endmodule

// File: tb/tb_mainCtrlDecoder.sv
`timescale 1ns/1ps
module tb_mainCtrlDecoder;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [5:0] opcode = 6'b111111;
  logic [1:0] regDst, memToReg, aluOp;
  logic aluSrc, regWrite, memRead, memWrite, branch, jump;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  mainCtrlDecoder dut (
    .opcode(opcode), .regDst(regDst), .aluSrc(aluSrc), .memToReg(memToReg),
    .regWrite(regWrite), .memRead(memRead), .memWrite(memWrite),
    .branch(branch), .aluOp(aluOp), .jump(jump)
  );

  // vector order: regDst, aluSrc, memToReg, regWrite, memRead, memWrite, branch, aluOp, jump
  function automatic logic [11:0] expVec(input logic [5:0] op);
    case (op)
      6'b000000: expVec = {2'b01, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 2'b10, 1'b0};
      6'b100011: expVec = {2'b00, 1'b1, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0};
      6'b101011: expVec = {2'b00, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0};
      6'b000100: expVec = {2'b00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 2'b01, 1'b0};
      6'b000010: expVec = {2'b00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1};
      6'b000011: expVec = {2'b10, 1'b0, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1};
      default:   expVec = 12'h000;
    endcase
  endfunction

  function automatic logic [11:0] actVec();
    actVec = {regDst, aluSrc, memToReg, regWrite, memRead, memWrite, branch, aluOp, jump};
  endfunction

  task automatic compare(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s op=%b actual=%b expected=%b", req, opcode, act, exp);
    end
  endtask

  task automatic applyAndCheck(input string req, input logic [5:0] op);
    @(posedge clk);
    opcode = op;
    @(negedge clk);
    compare(req, actVec(), expVec(op));
  endtask

  task automatic testReset();
    @(negedge clk);
    compare("R7 reset", actVec(), 12'h000);
    rst = 1'b0;
  endtask

  task automatic testRtype();  applyAndCheck("R1", 6'b000000); endtask
  task automatic testLoad();   applyAndCheck("R2", 6'b100011); endtask
  task automatic testStore();  applyAndCheck("R3", 6'b101011); endtask
  task automatic testBranch(); applyAndCheck("R4", 6'b000100); endtask
  task automatic testJump();   applyAndCheck("R5", 6'b000010); endtask
  task automatic testLink();   applyAndCheck("R6", 6'b000011); endtask

  task automatic testUnknown();
    applyAndCheck("R7", 6'b000001);
    applyAndCheck("R7", 6'b100111);
    applyAndCheck("R7", 6'b101010);
    applyAndCheck("R7", 6'b111111);
  endtask

  task automatic testNoClock();
    @(negedge clk);
    opcode = 6'b000011;
    #1 compare("R8 link", actVec(), expVec(6'b000011));
    opcode = 6'b100011;
    #1 compare("R8 load", actVec(), expVec(6'b100011));
    opcode = 6'b010101;
    #1 compare("R8 unknown", actVec(), 12'h000);
  endtask

  task automatic testSweep();
    for (int i = 0; i < 64; i++) begin
      applyAndCheck("R7 sweep", i[5:0]);
      checks++;
      if ((memRead && memWrite) || (regWrite && memWrite)) begin
        fails++;
        $display("FAIL R9 op=%b actual=%b%b%b expected=no overlap", opcode, memRead, memWrite, regWrite);
      end
      checks++;
      if ((regDst == 2'b10) != (memToReg == 2'b10)) begin
        fails++;
        $display("FAIL R10 op=%b actual=%b/%b expected=paired", opcode, regDst, memToReg);
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    testReset();
    testRtype();
    testLoad();
    testStore();
    testBranch();
    testJump();
    testLink();
    testUnknown();
    testNoClock();
    testSweep();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule